// File: doc/BRIEF.md
# Single-Instruction Subtract-and-Branch Processor Core

This block is a processor whose only instruction subtracts one memory word from another and branches when the result is not positive. There is no opcode. Every instruction is three consecutive words starting at the program counter: a source address, a destination address and a branch target. The core reads both operands and stores the destination minus the source back into the destination. When the stored value is zero or negative, it jumps to the target. Otherwise it moves on by three words. A source or destination address with its sign bit set stops the machine before any write. So does a next program counter that would be negative.

Program and data share one internal word-addressed RAM with a single synchronous port. Before start and after the machine stops, a host port can write any word of that RAM and read it back, so a program can be loaded and its results inspected. A pulse on `start` begins execution at address 0. The core spends seven clocks on each instruction and asserts `halted` when it stops. A cycle counter reports how many clocks execution took.

Top module: `subnp_core`

## Requirements
- R1: After reset `halted` is 0, `cycle_cnt` is 0, and the core waits for `start`. Execution then begins with the instruction at address 0.
- R2: An instruction at program counter p uses word p as source address A, word p+1 as destination address B and word p+2 as target T. It stores mem[B] - mem[A], wrapped to WORD_W bits in two's complement, into mem[B] with exactly one write.
- R3: If the stored result, read as a signed value, is greater than zero, the next program counter is p+3.
- R4: If the stored result is zero or negative, the next program counter is T. A target equal to p+3 therefore gives a plain subtract.
- R5: If A or B has its most significant bit set, the core halts after the fetch and writes nothing. A halt of this kind takes 4 counted cycles.
- R6: A next program counter with its most significant bit set halts the core. This covers both a taken branch to a negative T and a p+3 that overflows. An instruction that completes takes 7 counted cycles.
- R7: `halted` stays 1 until reset. Once halted, `start` has no effect and `cycle_cnt` holds its value.
- R8: `cycle_cnt` rises by one on every clock from the first clock after `start` until the core halts.
- R9: Host writes (`host_we`, `host_addr`, `host_wdata`) take effect only while the core is idle or halted. In those states `host_rdata` shows mem[`host_addr`] one clock after the address is presented. Host writes issued while the core runs are dropped.
- R10: A non-negative address, or a program counter plus 1 or plus 2, selects the RAM word given by its low ADDR_W bits. Addresses wrap modulo the depth 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins execution at address 0 when idle |
| halted | output | 1 | Core has stopped (sticky until reset) |
| cycle_cnt | output | CNT_W | Clocks spent executing |
| host_we | input | 1 | Host write strobe, honoured when idle or halted |
| host_addr | input | ADDR_W | Host word address |
| host_wdata | input | WORD_W | Host write data |
| host_rdata | output | WORD_W | RAM word read one clock after host_addr |

## Verification
The bench is built with 8-bit words and a 32-word RAM. It runs a one-instruction probe program over a grid of operand pairs, plus every pairing of the sign and overflow edge values, including equal operands and the most negative value. The final memory word gives the wrapped difference. A marker cell, cleared only on the branch path, together with the cycle count (11 versus 14), shows whether the result sign sent execution to the fall-through or the branch path. Separate programs cover the remaining cases: a negative source or destination address, which gives a 4-cycle halt with memory untouched; a p+3 that wraps negative from a program counter whose operand words wrap around the RAM; operand addresses above the depth; and host writes issued during execution against host writes issued after the halt.

// File: rtl/subnp_pkg.sv
package subnp_pkg;
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_FETCH_A,
      ST_FETCH_B,
      ST_FETCH_C,
      ST_READ_MA,
      ST_READ_MB,
      ST_WRITE,
      ST_NEXT,
      ST_HALT
   } seq_state_e;

   localparam int unsigned INSTR_WORDS = 3;
endpackage

// File: rtl/subnp_ram.sv
module subnp_ram #(
   parameter int unsigned WORD_W = 16,
   parameter int unsigned ADDR_W = 8
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [WORD_W-1:0] din,
   output logic [WORD_W-1:0] dout
);
   localparam int unsigned DEPTH = 1 << ADDR_W;

   if (ADDR_W < 2 || ADDR_W > 12) begin : g_bad_depth
      $error("subnp_ram: ADDR_W out of range");
   end

   logic [WORD_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         cells[addr] <= din;
      end
      dout <= cells[addr];
   end
endmodule

// File: rtl/subnp_cyc.sv
module subnp_cyc #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   output logic [CNT_W-1:0] count
);
   if (CNT_W < 4) begin : g_bad_cnt
      $error("subnp_cyc: CNT_W too small");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (en) begin
         count <= count + CNT_W'(1);
      end
   end
endmodule

// File: rtl/subnp_seq.sv
module subnp_seq
   import subnp_pkg::*;
#(
   parameter int unsigned WORD_W = 16,
   parameter int unsigned ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [WORD_W-1:0] rd_data,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_we,
   output logic [WORD_W-1:0] mem_wdata,
   output logic              active,
   output logic              halted,
   output logic [WORD_W-1:0] pc
);
   localparam int unsigned SIGN = WORD_W - 1;

   if (WORD_W <= ADDR_W) begin : g_bad_word
      $error("subnp_seq: WORD_W must exceed ADDR_W");
   end

   seq_state_e        state;
   logic [WORD_W-1:0] op_a, op_b, op_c, val_a;
   logic              res_np;
   logic [WORD_W-1:0] pc_p1, pc_p2, pc_p3, next_pc, diff;

   assign pc_p1   = pc + WORD_W'(1);
   assign pc_p2   = pc + WORD_W'(2);
   assign pc_p3   = pc + WORD_W'(INSTR_WORDS);
   assign next_pc = res_np ? op_c : pc_p3;
   assign diff    = rd_data - val_a;

   assign active = (state != ST_IDLE) && (state != ST_HALT);
   assign halted = (state == ST_HALT);

   always_comb begin
      mem_addr  = '0;
      mem_we    = 1'b0;
      mem_wdata = diff;
      case (state)
         ST_FETCH_A: mem_addr = pc[ADDR_W-1:0];
         ST_FETCH_B: mem_addr = pc_p1[ADDR_W-1:0];
         ST_FETCH_C: mem_addr = pc_p2[ADDR_W-1:0];
         ST_READ_MA: mem_addr = op_a[ADDR_W-1:0];
         ST_READ_MB: mem_addr = op_b[ADDR_W-1:0];
         ST_WRITE: begin
            mem_addr = op_b[ADDR_W-1:0];
            mem_we   = 1'b1;
         end
         default: mem_addr = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         pc     <= '0;
         op_a   <= '0;
         op_b   <= '0;
         op_c   <= '0;
         val_a  <= '0;
         res_np <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (start) begin
                  pc    <= '0;
                  state <= ST_FETCH_A;
               end
            end
            ST_FETCH_A: state <= ST_FETCH_B;
            ST_FETCH_B: begin
               op_a  <= rd_data;
               state <= ST_FETCH_C;
            end
            ST_FETCH_C: begin
               op_b  <= rd_data;
               state <= ST_READ_MA;
            end
            ST_READ_MA: begin
               op_c <= rd_data;
               if (op_a[SIGN] || op_b[SIGN]) begin
                  state <= ST_HALT;
               end else begin
                  state <= ST_READ_MB;
               end
            end
            ST_READ_MB: begin
               val_a <= rd_data;
               state <= ST_WRITE;
            end
            ST_WRITE: begin
               res_np <= diff[SIGN] || (diff == '0);
               state  <= ST_NEXT;
            end
            ST_NEXT: begin
               if (next_pc[SIGN]) begin
                  state <= ST_HALT;
               end else begin
                  pc    <= next_pc;
                  state <= ST_FETCH_A;
               end
            end
            default: state <= ST_HALT;
         endcase
      end
   end
endmodule

// File: rtl/subnp_core.sv
module subnp_core #(
   parameter int unsigned WORD_W = 16,
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned CNT_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              halted,
   output logic [CNT_W-1:0]  cycle_cnt,
   input  logic              host_we,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [WORD_W-1:0] host_wdata,
   output logic [WORD_W-1:0] host_rdata
);
   logic              core_active;
   logic [ADDR_W-1:0] core_addr;
   logic              core_we;
   logic [WORD_W-1:0] core_wdata;
   logic [WORD_W-1:0] core_pc;
   logic [ADDR_W-1:0] ram_addr;
   logic              ram_we;
   logic [WORD_W-1:0] ram_din;
   logic [WORD_W-1:0] ram_dout;

   assign ram_addr   = core_active ? core_addr  : host_addr;
   assign ram_we     = core_active ? core_we    : host_we;
   assign ram_din    = core_active ? core_wdata : host_wdata;
   assign host_rdata = ram_dout;

   subnp_ram #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_ram (
      .clk  (clk),
      .we   (ram_we),
      .addr (ram_addr),
      .din  (ram_din),
      .dout (ram_dout)
   );

   subnp_seq #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .rd_data   (ram_dout),
      .mem_addr  (core_addr),
      .mem_we    (core_we),
      .mem_wdata (core_wdata),
      .active    (core_active),
      .halted    (halted),
      .pc        (core_pc)
   );

   subnp_cyc #(.CNT_W(CNT_W)) u_cyc (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (core_active),
      .count (cycle_cnt)
   );
endmodule

// File: rtl/subnp_chk.sv
module subnp_chk #(
   parameter int unsigned WORD_W = 16,
   parameter int unsigned CNT_W  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              halted,
   input logic              active,
   input logic [CNT_W-1:0]  cyc,
   input logic              mem_we,
   input logic [WORD_W-1:0] pc
);
   // R1
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && !halted) |-> (cyc == '0));

   // R7
   halted_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted);

   // R7
   cnt_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> $stable(cyc));

   // R8
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      active |=> (cyc == $past(cyc) + CNT_W'(1)));

   // R6
   pc_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> !pc[WORD_W-1]);

   // R2
   single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && active) |=> !mem_we);
endmodule

bind subnp_core subnp_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .halted (halted),
   .active (core_active),
   .cyc    (cycle_cnt),
   .mem_we (ram_we),
   .pc     (core_pc)
);

// File: tb/test_subnp_core.sv
module test_subnp_core;
   localparam int WW = 8;
   localparam int AW = 5;
   localparam int CW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          halted;
   logic [CW-1:0] cycle_cnt;
   logic          host_we = 1'b0;
   logic [AW-1:0] host_addr = '0;
   logic [WW-1:0] host_wdata = '0;
   logic [WW-1:0] host_rdata;

   int total = 0;
   int bad = 0;

   always #2.5 clk = ~clk;

   subnp_core #(.WORD_W(WW), .ADDR_W(AW), .CNT_W(CW)) i_subnp_core (
      .clk(clk), .rst_n(rst_n), .start(start), .halted(halted),
      .cycle_cnt(cycle_cnt), .host_we(host_we), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata)
   );

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr(input int a, input int d);
      host_we = 1'b1; host_addr = AW'(a); host_wdata = WW'(d);
      @(negedge clk);
      host_we = 1'b0;
   endtask

   task automatic rd(input int a, output int d);
      host_addr = AW'(a);
      @(negedge clk);
      d = int'(host_rdata);
   endtask

   task automatic run(input bit meddle, output int cyc);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (meddle) begin
         host_we = 1'b1; host_addr = AW'(25); host_wdata = 8'h44;
         @(negedge clk);
         host_we = 1'b0;
      end
      for (int i = 0; i < 200 && !halted; i++) @(negedge clk);
      cyc = int'(cycle_cnt);
   endtask

   // Probe: 0:(16,17,6)  3:(-1,0,0) operand halt  6:(18,18,-1) branch halt
   task automatic probe(input int x, input int y);
      int cyc, v17, v18, r;
      bit np;
      do_reset();
      wr(0, 16); wr(1, 17); wr(2, 6);
      wr(3, 8'hFF); wr(4, 0); wr(5, 0);
      wr(6, 18); wr(7, 18); wr(8, 8'hFF);
      wr(16, x); wr(17, y); wr(18, 5);
      run(1'b0, cyc);
      rd(17, v17); rd(18, v18);
      r  = (y - x) & 8'hFF;
      np = (r == 0) || r[7];
      chk($sformatf("R2 diff x=%0d y=%0d", x, y), v17, r);
      if (np) begin
         chk($sformatf("R4 branch marker x=%0d y=%0d", x, y), v18, 0);
         chk($sformatf("R8 R6 cycles branch x=%0d y=%0d", x, y), cyc, 14);
      end else begin
         chk($sformatf("R3 fallthrough marker x=%0d y=%0d", x, y), v18, 5);
         chk($sformatf("R8 R5 cycles fallthrough x=%0d y=%0d", x, y), cyc, 11);
      end
   endtask

   initial begin
      int cyc, v, cyc0;
      int edges [6] = '{0, 1, 8'h7F, 8'h80, 8'h81, 8'hFF};

      do_reset();
      // R1 reset state
      chk("R1 halted after reset", int'(halted), 0);
      chk("R1 cycle_cnt after reset", int'(cycle_cnt), 0);

      // sweep grid and edge pairs (R2 R3 R4 R8)
      for (int x = 0; x < 256; x += 17)
         for (int y = 0; y < 256; y += 17)
            probe(x, y);
      for (int i = 0; i < 6; i++)
         for (int j = 0; j < 6; j++)
            probe(edges[i], edges[j]);

      // R4 target = p+3 acts as plain subtract
      do_reset();
      wr(0, 16); wr(1, 17); wr(2, 3); wr(3, 8'hFF); wr(4, 0); wr(5, 0);
      wr(16, 5); wr(17, 5);
      run(1'b0, cyc);
      rd(17, v);
      chk("R4 plain subtract result", v, 0);
      chk("R4 plain subtract cycles", cyc, 11);

      // R5 negative destination address: no write
      do_reset();
      wr(0, 16); wr(1, 8'hFE); wr(2, 0); wr(16, 5); wr(30, 8'h33);
      run(1'b0, cyc);
      chk("R5 halted neg b", int'(halted), 1);
      chk("R5 cycles neg b", cyc, 4);
      rd(30, v); chk("R5 word 30 untouched", v, 8'h33);
      rd(16, v); chk("R5 word 16 untouched", v, 5);

      // R5 negative source address
      do_reset();
      wr(0, 8'h90); wr(1, 17); wr(2, 0); wr(16, 3); wr(17, 9);
      run(1'b0, cyc);
      chk("R5 cycles neg a", cyc, 4);
      rd(17, v); chk("R5 word 17 untouched", v, 9);

      // R6 R10: branch to 126 (words 30,31,0), then p+3 = 129 negative
      do_reset();
      wr(0, 20); wr(1, 20); wr(2, 126); wr(20, 0);
      wr(30, 22); wr(31, 23); wr(22, 0); wr(23, 5);
      run(1'b0, cyc);
      chk("R6 halted on wrapped pc", int'(halted), 1);
      chk("R6 cycles two instructions", cyc, 14);
      rd(23, v); chk("R10 wrapped fetch result", v, 5);

      // R10 R9: addresses 48,49 select words 16,17; host write while running dropped
      do_reset();
      wr(0, 48); wr(1, 49); wr(2, 3); wr(3, 8'hFF); wr(4, 0); wr(5, 0);
      wr(16, 2); wr(17, 7); wr(25, 8'h11);
      run(1'b1, cyc);
      rd(17, v); chk("R10 modulo address result", v, 5);
      chk("R10 cycles", cyc, 11);
      rd(25, v); chk("R9 running host write dropped", v, 8'h11);
      wr(25, 8'h66);
      rd(25, v); chk("R9 halted host write applied", v, 8'h66);

      // R7 sticky halt, start ignored, counter frozen
      cyc0 = int'(cycle_cnt);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (20) @(negedge clk);
      chk("R7 halted stays set", int'(halted), 1);
      chk("R7 cycle_cnt frozen", int'(cycle_cnt), cyc0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule